// File: doc/BRIEF.md
# Region-Based Memory Access Filter

The filter sits in front of a memory target and judges every read or write against a set of programmable address windows. Each window has a 4 KB-granular lower and upper bound, an enable, separate grants for secure reads and secure writes, and a mask that names which non-secure requesters may use it. An access is allowed only when it lands in exactly one enabled window and that window grants it. Accesses that land in no enabled window, or in more than one, are denied.

Denied accesses are logged separately for reads and for writes. Each direction keeps the first offending address, its security and privilege flags, and its master and access IDs until software clears the log. A later denial in the same direction while the log is still pending only raises an overrun flag. An interrupt line reports pending denials when reporting is enabled. Configuration and status go through a simple 32-bit register port with a one-cycle read latency.

Top module: `rgnf_top`

## Requirements
- R1: After reset every window is disabled, so every access is denied. Both direction logs read 0, `irq` is low and the control register at 0x000 reads 1 (interrupt reporting on).
- R2: `rsp_valid` is high exactly one cycle after a cycle with `req_valid` high. `rsp_allow` is high only together with `rsp_valid`. Register reads return `reg_rdata` one cycle after `reg_re`.
- R3: Window i has its registers at 0x100 + 0x20*i: +0x0 lower bound bits 31:0, +0x4 lower bound bits 63:32, +0x8 upper bound bits 31:0, +0xC upper bound bits 63:32. The upper bound is inclusive. Only address bits 63:12 are compared or stored, so the low word reads back with bits 11:0 as 0 for the lower bound and as 0xFFF for the upper bound.
- R4: Window word +0x10 holds the enable in bit 0, the secure-read grant in bit 30 and the secure-write grant in bit 31. A secure access is allowed only by the grant that matches its direction. A disabled window never matches.
- R5: Window word +0x14 is a 32-bit non-secure mask. A non-secure access is allowed only when mask bit `req_mid[4:0]` is 1, whatever its direction.
- R6: An access that matches no enabled window is denied. If the direction log is not pending, the access sets status bit 0.
- R7: An access that matches two or more enabled windows is denied. If the direction log is not pending, it sets status bit 16 and leaves bit 0 at 0.
- R8: The read log sits at 0x010 and the write log at 0x030. Each log has status at +0x0, fail address bits 31:0 at +0x8, fail address bits 63:32 at +0xC, control at +0x10 (bit 21 non-secure, bit 20 privileged) and ID at +0x14 (access ID in bits 27:8, master ID in bits 7:0). The first denial in a direction fills only that direction's log.
- R9: A denial while a direction's status bit 0 or bit 16 is set leaves the captured fields and those bits unchanged. It sets status bit 8 (overrun).
- R10: Writing 0x014 with bit 0 set clears both logs. A denial in the same cycle as the clear is captured as a fresh first denial, without overrun.
- R11: `irq` equals bit 0 of the control register at 0x000, ANDed with any status bit 0 or bit 16 set in either log. It changes on the clock edge that updates either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |
| req_valid | input | 1 | Access to judge this cycle |
| req_addr | input | 64 | Access byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | 1 = secure requester |
| req_priv | input | 1 | 1 = privileged access |
| req_mid | input | 8 | Master ID |
| req_aid | input | 20 | Access ID |
| rsp_valid | output | 1 | Verdict valid, one cycle after req_valid |
| rsp_allow | output | 1 | 1 = access allowed |
| irq | output | 1 | Pending denial report |

## Verification
The hardest situation to reach from the ports is a clear and a fresh denial landing in the same cycle. That needs the register strobe and the access strobe driven together while a log is already pending. The bench first raises a read denial, then drives the clear write and a new denied read on the same edge. It expects the new address with no overrun. Overlap is reached by programming two windows that share pages. A random phase then places a handful of short windows, some of them overlapping, in a small page range, and fires random accesses, clears and status reads at them. Misses, overlaps, overruns and mask lookups all follow from those settings.

// File: rtl/rgnf_pkg.sv
package rgnf_pkg;
  // granule of the window bounds
  localparam int unsigned PAGE_SH    = 12;
  // register map
  localparam int unsigned OFF_CTRL   = 12'h000;
  localparam int unsigned OFF_CLEAR  = 12'h014;
  localparam int unsigned OFF_LOG0   = 12'h010;
  localparam int unsigned LOG_STRIDE = 12'h020;
  localparam int unsigned OFF_RGN    = 12'h100;
  localparam int unsigned RGN_SH     = 5;
  // offsets inside one log set
  localparam int unsigned LOG_ST     = 12'h00;
  localparam int unsigned LOG_ALO    = 12'h08;
  localparam int unsigned LOG_AHI    = 12'h0C;
  localparam int unsigned LOG_CT     = 12'h10;
  localparam int unsigned LOG_ID     = 12'h14;
  // bit positions
  localparam int unsigned ST_PERM    = 0;
  localparam int unsigned ST_OVR     = 8;
  localparam int unsigned ST_OVL     = 16;
  localparam int unsigned CT_NS      = 21;
  localparam int unsigned CT_PRIV    = 20;
  localparam int unsigned ID_AID_LSB = 8;
  localparam int unsigned AT_EN      = 0;
  localparam int unsigned AT_SRD     = 30;
  localparam int unsigned AT_SWR     = 31;

  typedef enum logic [2:0] {
    W_BASE_LO = 3'd0,
    W_BASE_HI = 3'd1,
    W_TOP_LO  = 3'd2,
    W_TOP_HI  = 3'd3,
    W_ATTR    = 3'd4,
    W_MASK    = 3'd5
  } rgn_word_e;
endpackage

// File: rtl/rgnf_bank.sv
module rgnf_bank
  import rgnf_pkg::*;
#(
  parameter int unsigned NUM_RGN = 17,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned MASK_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_RGN),
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        word,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data,
  input  logic [PAGE_W-1:0] req_page,
  output logic [NUM_RGN-1:0] hit,
  output logic [NUM_RGN-1:0] swr,
  output logic [NUM_RGN-1:0] srd,
  output logic [MASK_W-1:0]  mask [NUM_RGN]
);
  localparam int unsigned LO_W = 32 - PAGE_SH;

  logic [PAGE_W-1:0]  base_pg [NUM_RGN];
  logic [PAGE_W-1:0]  top_pg  [NUM_RGN];
  logic [NUM_RGN-1:0] en_q;
  logic [NUM_RGN-1:0] swr_q;
  logic [NUM_RGN-1:0] srd_q;
  logic [MASK_W-1:0]  mask_q  [NUM_RGN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_RGN; i++) begin
        base_pg[i] <= '0;
        top_pg[i]  <= '0;
        mask_q[i]  <= '0;
      end
      en_q  <= '0;
      swr_q <= '0;
      srd_q <= '0;
    end else if (wr_en) begin
      case (rgn_word_e'(word))
        W_BASE_LO: base_pg[idx][LO_W-1:0]      <= wdata[31:PAGE_SH];
        W_BASE_HI: base_pg[idx][PAGE_W-1:LO_W] <= wdata[PAGE_W-LO_W-1:0];
        W_TOP_LO:  top_pg[idx][LO_W-1:0]       <= wdata[31:PAGE_SH];
        W_TOP_HI:  top_pg[idx][PAGE_W-1:LO_W]  <= wdata[PAGE_W-LO_W-1:0];
        W_ATTR: begin
          en_q[idx]  <= wdata[AT_EN];
          srd_q[idx] <= wdata[AT_SRD];
          swr_q[idx] <= wdata[AT_SWR];
        end
        W_MASK:    mask_q[idx] <= wdata[MASK_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rgn_word_e'(word))
      W_BASE_LO: rd_data = {base_pg[idx][LO_W-1:0], {PAGE_SH{1'b0}}};
      W_BASE_HI: rd_data = 32'(base_pg[idx][PAGE_W-1:LO_W]);
      W_TOP_LO:  rd_data = {top_pg[idx][LO_W-1:0], {PAGE_SH{1'b1}}};
      W_TOP_HI:  rd_data = 32'(top_pg[idx][PAGE_W-1:LO_W]);
      W_ATTR: begin
        rd_data[AT_EN]  = en_q[idx];
        rd_data[AT_SRD] = srd_q[idx];
        rd_data[AT_SWR] = swr_q[idx];
      end
      W_MASK:    rd_data = 32'(mask_q[idx]);
      default:   rd_data = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_cmp
    assign hit[i]  = en_q[i] && (req_page >= base_pg[i]) && (req_page <= top_pg[i]);
    assign mask[i] = mask_q[i];
  end
  assign swr = swr_q;
  assign srd = srd_q;
endmodule

// File: rtl/rgnf_judge.sv
module rgnf_judge #(
  parameter int unsigned NUM_RGN = 17,
  parameter int unsigned MASK_W  = 32,
  localparam int unsigned SEL_W  = $clog2(MASK_W)
) (
  input  logic [NUM_RGN-1:0] hit,
  input  logic [NUM_RGN-1:0] swr,
  input  logic [NUM_RGN-1:0] srd,
  input  logic [MASK_W-1:0]  mask [NUM_RGN],
  input  logic               req_write,
  input  logic               req_secure,
  input  logic [SEL_W-1:0]   mid_sel,
  output logic               allow,
  output logic               overlap
);
  logic [NUM_RGN-1:0] grant;

  for (genvar i = 0; i < NUM_RGN; i++) begin : g_grant
    assign grant[i] = req_secure ? (req_write ? swr[i] : srd[i]) : mask[i][mid_sel];
  end

  // more than one bit set in hit
  assign overlap = |(hit & (hit - NUM_RGN'(1)));
  assign allow   = (|hit) && !overlap && (|(hit & grant));
endmodule

// File: rtl/rgnf_log.sv
module rgnf_log #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MID_W  = 8,
  parameter int unsigned AID_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              evt,
  input  logic              evt_ovl,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic              evt_ns,
  input  logic              evt_priv,
  input  logic [MID_W-1:0]  evt_mid,
  input  logic [AID_W-1:0]  evt_aid,
  output logic              st_perm,
  output logic              st_ovr,
  output logic              st_ovl,
  output logic [ADDR_W-1:0] f_addr,
  output logic              f_ns,
  output logic              f_priv,
  output logic [MID_W-1:0]  f_mid,
  output logic [AID_W-1:0]  f_aid
);
  logic pend_eff;
  assign pend_eff = (st_perm | st_ovl) & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_perm <= 1'b0;
      st_ovr  <= 1'b0;
      st_ovl  <= 1'b0;
      f_addr  <= '0;
      f_ns    <= 1'b0;
      f_priv  <= 1'b0;
      f_mid   <= '0;
      f_aid   <= '0;
    end else begin
      if (clr) begin
        st_perm <= 1'b0;
        st_ovr  <= 1'b0;
        st_ovl  <= 1'b0;
      end
      if (evt) begin
        if (pend_eff) begin
          st_ovr <= 1'b1;
        end else begin
          st_perm <= ~evt_ovl;
          st_ovl  <= evt_ovl;
          f_addr  <= evt_addr;
          f_ns    <= evt_ns;
          f_priv  <= evt_priv;
          f_mid   <= evt_mid;
          f_aid   <= evt_aid;
        end
      end
    end
  end
endmodule

// File: rtl/rgnf_top.sv
module rgnf_top
  import rgnf_pkg::*;
#(
  parameter int unsigned NUM_RGN = 17,
  parameter int unsigned ADDR_W  = 64,
  parameter int unsigned MID_W   = 8,
  parameter int unsigned AID_W   = 20,
  parameter int unsigned MASK_W  = 32,
  parameter int unsigned REG_AW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_secure,
  input  logic              req_priv,
  input  logic [MID_W-1:0]  req_mid,
  input  logic [AID_W-1:0]  req_aid,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              irq
);
  localparam int unsigned IDX_W  = $clog2(NUM_RGN);
  localparam int unsigned PAGE_W = ADDR_W - PAGE_SH;
  localparam int unsigned SEL_W  = $clog2(MASK_W);

  // register decode
  logic [REG_AW-1:0] rgn_rel;
  logic              rgn_sel;
  logic [IDX_W-1:0]  rgn_idx;
  logic [2:0]        rgn_word;
  assign rgn_rel  = reg_addr - REG_AW'(OFF_RGN);
  assign rgn_sel  = (reg_addr >= REG_AW'(OFF_RGN)) && (rgn_rel[1:0] == 2'b00)
                 && ((rgn_rel >> RGN_SH) < REG_AW'(NUM_RGN));
  assign rgn_idx  = rgn_rel[RGN_SH +: IDX_W];
  assign rgn_word = rgn_rel[4:2];

  logic [31:0]        bank_rd;
  logic [NUM_RGN-1:0] hit, swr, srd;
  logic [MASK_W-1:0]  mask [NUM_RGN];

  rgnf_bank #(.NUM_RGN(NUM_RGN), .ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_bank (
    .clk(clk), .rst(rst),
    .wr_en(reg_we && rgn_sel), .idx(rgn_idx), .word(rgn_word),
    .wdata(reg_wdata), .rd_data(bank_rd),
    .req_page(req_addr[ADDR_W-1:PAGE_SH]),
    .hit(hit), .swr(swr), .srd(srd), .mask(mask)
  );

  logic allow, overlap;
  rgnf_judge #(.NUM_RGN(NUM_RGN), .MASK_W(MASK_W)) u_judge (
    .hit(hit), .swr(swr), .srd(srd), .mask(mask),
    .req_write(req_write), .req_secure(req_secure),
    .mid_sel(req_mid[SEL_W-1:0]),
    .allow(allow), .overlap(overlap)
  );

  logic clr, irq_en;
  assign clr = reg_we && (reg_addr == REG_AW'(OFF_CLEAR)) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst)                                            irq_en <= 1'b1;
    else if (reg_we && reg_addr == REG_AW'(OFF_CTRL))   irq_en <= reg_wdata[0];
  end

  // one log per direction: 0 = read, 1 = write
  logic [1:0]        st_perm, st_ovr, st_ovl, f_ns, f_priv;
  logic [ADDR_W-1:0] f_addr [2];
  logic [MID_W-1:0]  f_mid  [2];
  logic [AID_W-1:0]  f_aid  [2];

  for (genvar d = 0; d < 2; d++) begin : g_log
    rgnf_log #(.ADDR_W(ADDR_W), .MID_W(MID_W), .AID_W(AID_W)) u_log (
      .clk(clk), .rst(rst), .clr(clr),
      .evt(req_valid && !allow && (req_write == 1'(d))),
      .evt_ovl(overlap), .evt_addr(req_addr),
      .evt_ns(!req_secure), .evt_priv(req_priv),
      .evt_mid(req_mid), .evt_aid(req_aid),
      .st_perm(st_perm[d]), .st_ovr(st_ovr[d]), .st_ovl(st_ovl[d]),
      .f_addr(f_addr[d]), .f_ns(f_ns[d]), .f_priv(f_priv[d]),
      .f_mid(f_mid[d]), .f_aid(f_aid[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_allow <= req_valid && allow;
    end
  end

  assign irq = irq_en && (|(st_perm | st_ovl));

  // register read path
  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (rgn_sel) begin
      rd_mux = bank_rd;
    end else if (reg_addr == REG_AW'(OFF_CTRL)) begin
      rd_mux[0] = irq_en;
    end else begin
      for (int d = 0; d < 2; d++) begin
        if (reg_addr == REG_AW'(OFF_LOG0 + d * LOG_STRIDE + LOG_ST)) begin
          rd_mux[ST_PERM] = st_perm[d];
          rd_mux[ST_OVR]  = st_ovr[d];
          rd_mux[ST_OVL]  = st_ovl[d];
        end
        if (reg_addr == REG_AW'(OFF_LOG0 + d * LOG_STRIDE + LOG_ALO))
          rd_mux = f_addr[d][31:0];
        if (reg_addr == REG_AW'(OFF_LOG0 + d * LOG_STRIDE + LOG_AHI))
          rd_mux = 32'(f_addr[d][ADDR_W-1:32]);
        if (reg_addr == REG_AW'(OFF_LOG0 + d * LOG_STRIDE + LOG_CT)) begin
          rd_mux[CT_NS]   = f_ns[d];
          rd_mux[CT_PRIV] = f_priv[d];
        end
        if (reg_addr == REG_AW'(OFF_LOG0 + d * LOG_STRIDE + LOG_ID)) begin
          rd_mux[MID_W-1:0]               = f_mid[d];
          rd_mux[ID_AID_LSB +: AID_W]     = f_aid[d];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rgnf_chk.sv
module rgnf_chk #(
  parameter int unsigned REG_AW = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic              rsp_allow,
  input logic              irq
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R2
  allow_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_allow |-> rsp_valid);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !irq));
  // R10
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_addr == REG_AW'(12'h014) && reg_wdata[0] && !req_valid) |=> !irq);
  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ((rsp_valid && !rsp_allow) || $past(reg_we)));
endmodule

bind rgnf_top rgnf_chk #(.REG_AW(REG_AW)) u_rgnf_chk (.*);

// File: tb/test_rgnf_top.sv
module test_rgnf_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_priv = 1'b0;
  logic [63:0] req_addr = '0;
  logic [7:0]  req_mid = '0;
  logic [19:0] req_aid = '0;
  logic        rsp_valid, rsp_allow, irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  rgnf_top i_rgnf_top (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_write(req_write), .req_secure(req_secure),
    .req_priv(req_priv), .req_mid(req_mid), .req_aid(req_aid),
    .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  logic [51:0] m_base [NR], m_top [NR];
  bit          m_en [NR], m_swr [NR], m_srd [NR];
  logic [31:0] m_mask [NR];
  bit          m_act = 1;
  bit          m_perm [2], m_ovr [2], m_ovl [2], m_fns [2], m_fpriv [2];
  logic [63:0] m_faddr [2];
  logic [7:0]  m_fmid [2];
  logic [19:0] m_faid [2];

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] f_eval(logic [63:0] a, bit wr, bit sec, logic [7:0] mid);
    int n = 0;
    bit g = 0;
    for (int i = 0; i < NR; i++) begin
      if (m_en[i] && a[63:12] >= m_base[i] && a[63:12] <= m_top[i]) begin
        n++;
        g = sec ? (wr ? m_swr[i] : m_srd[i]) : m_mask[i][mid[4:0]];
      end
    end
    return {n > 1, n == 1 && g};
  endfunction

  function automatic bit exp_irq();
    return m_act && (m_perm[0] || m_ovl[0] || m_perm[1] || m_ovl[1]);
  endfunction

  task automatic m_log(int d, bit ovl, logic [63:0] a, bit ns, bit pv, logic [7:0] mid, logic [19:0] aid);
    if (m_perm[d] || m_ovl[d]) m_ovr[d] = 1;
    else begin
      m_perm[d] = !ovl; m_ovl[d] = ovl; m_faddr[d] = a;
      m_fns[d] = ns; m_fpriv[d] = pv; m_fmid[d] = mid; m_faid[d] = aid;
    end
  endtask

  task automatic m_clear();
    for (int d = 0; d < 2; d++) begin m_perm[d] = 0; m_ovr[d] = 0; m_ovl[d] = 0; end
  endtask

  task automatic reg_wr(logic [11:0] a, logic [31:0] v);
    reg_we = 1; reg_addr = a; reg_wdata = v;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic reg_rd(logic [11:0] a, output logic [31:0] v);
    reg_re = 1; reg_addr = a;
    @(posedge clk); @(negedge clk);
    reg_re = 0; v = reg_rdata;
  endtask

  task automatic set_rgn(int i, logic [63:0] b, logic [63:0] t, logic [31:0] at, logic [31:0] mk);
    logic [11:0] o;
    o = 12'(12'h100 + 32 * i);
    reg_wr(o + 12'h00, b[31:0]);  reg_wr(o + 12'h04, b[63:32]);
    reg_wr(o + 12'h08, t[31:0]);  reg_wr(o + 12'h0C, t[63:32]);
    reg_wr(o + 12'h10, at);       reg_wr(o + 12'h14, mk);
    m_base[i] = b[63:12]; m_top[i] = t[63:12];
    m_en[i] = at[0]; m_srd[i] = at[30]; m_swr[i] = at[31]; m_mask[i] = mk;
  endtask

  task automatic access(string rq, logic [63:0] a, bit wr, bit sec, bit pv,
                        logic [7:0] mid, logic [19:0] aid);
    logic [1:0] e;
    e = f_eval(a, wr, sec, mid);
    req_valid = 1; req_addr = a; req_write = wr; req_secure = sec;
    req_priv = pv; req_mid = mid; req_aid = aid;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk(rq, "rsp_valid", 64'(rsp_valid), 64'(1));
    chk(rq, "rsp_allow", 64'(rsp_allow), 64'(e[0]));
    if (!e[0]) m_log(wr ? 1 : 0, e[1], a, !sec, pv, mid, aid);
    chk("R11", "irq", 64'(irq), 64'(exp_irq()));
  endtask

  task automatic check_status(int d, string rq);
    logic [31:0] v;
    reg_rd(12'(12'h010 + 32 * d), v);
    chk(rq, "status", 64'(v), 64'({m_ovl[d], 7'b0, m_ovr[d], 7'b0, m_perm[d]}));
  endtask

  task automatic check_fail(int d, string rq);
    logic [31:0] v;
    logic [11:0] b;
    b = 12'(12'h010 + 32 * d);
    reg_rd(b + 12'h08, v); chk(rq, "fail addr lo", 64'(v), 64'(m_faddr[d][31:0]));
    reg_rd(b + 12'h0C, v); chk(rq, "fail addr hi", 64'(v), 64'(m_faddr[d][63:32]));
    reg_rd(b + 12'h10, v); chk(rq, "fail ctrl", 64'(v), 64'({10'b0, m_fns[d], m_fpriv[d], 20'b0}));
    reg_rd(b + 12'h14, v); chk(rq, "fail id", 64'(v), 64'({4'b0, m_faid[d], m_fmid[d]}));
  endtask

  task automatic do_clear();
    reg_wr(12'h014, 32'h1);
    m_clear();
    chk("R10", "irq after clear", 64'(irq), 64'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NR; i++) begin
      m_base[i] = '0; m_top[i] = '0; m_en[i] = 0; m_swr[i] = 0; m_srd[i] = 0; m_mask[i] = '0;
    end
    m_clear();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    chk("R1", "irq", 64'(irq), 64'(0));
    reg_rd(12'h000, v); chk("R1", "ctrl", 64'(v), 64'(1));
    check_status(0, "R1"); check_status(1, "R1");
    reg_rd(12'h110, v); chk("R1", "rgn0 attr", 64'(v), 64'(0));
    access("R1", 64'h1000, 0, 1, 0, 8'd0, 20'd0);
    do_clear();

    // R3 bounds, granularity, readback
    set_rgn(0, 64'h1ABC, 64'h1005, 32'hC000_0001, 32'h0);
    reg_rd(12'h100, v); chk("R3", "base lo", 64'(v), 64'h1000);
    reg_rd(12'h108, v); chk("R3", "top lo", 64'(v), 64'h1FFF);
    access("R3", 64'h1000, 0, 1, 0, 8'd1, 20'd1);
    access("R3", 64'h1FFF, 0, 1, 0, 8'd1, 20'd1);
    access("R6", 64'h2000, 0, 1, 1, 8'd2, 20'h12345);
    access("R9", 64'h0FFF, 0, 1, 0, 8'd3, 20'h00007);
    check_status(0, "R9"); check_fail(0, "R9");
    check_status(1, "R8");
    do_clear();
    check_status(0, "R10"); check_status(1, "R10");

    // R4 secure grants and enable
    set_rgn(0, 64'h1000, 64'h1FFF, 32'h8000_0001, 32'h0);
    access("R4", 64'h1800, 1, 1, 0, 8'd0, 20'd0);
    access("R4", 64'h1800, 0, 1, 0, 8'd0, 20'd0);
    reg_wr(12'h110, 32'h4000_0001); m_swr[0] = 0; m_srd[0] = 1;
    access("R4", 64'h1800, 0, 1, 0, 8'd0, 20'd0);
    access("R4", 64'h1800, 1, 1, 0, 8'd0, 20'd0);
    reg_wr(12'h110, 32'hC000_0000); m_swr[0] = 1; m_en[0] = 0;
    access("R4", 64'h1800, 0, 1, 0, 8'd0, 20'd0);
    do_clear();

    // R5 non-secure mask
    set_rgn(0, 64'h1000, 64'h1FFF, 32'h0000_0001, 32'h0000_0008);
    access("R5", 64'h1400, 0, 0, 0, 8'd3, 20'd0);
    access("R5", 64'h1400, 1, 0, 0, 8'd3, 20'd0);
    access("R5", 64'h1400, 0, 0, 0, 8'd35, 20'd0);
    access("R5", 64'h1400, 0, 0, 0, 8'd4, 20'd0);
    access("R4", 64'h1400, 0, 1, 0, 8'd3, 20'd0);
    do_clear();

    // R7 overlap
    set_rgn(0, 64'h1000, 64'h1FFF, 32'hC000_0001, 32'h0);
    set_rgn(1, 64'h1000, 64'h3FFF, 32'hC000_0001, 32'h0);
    access("R7", 64'h1800, 1, 1, 0, 8'd9, 20'd9);
    check_status(1, "R7");
    access("R7", 64'h2800, 1, 1, 0, 8'd9, 20'd9);
    do_clear();

    // R8 write log fields, R9 overrun keeps them
    access("R8", 64'h2804, 1, 0, 1, 8'd5, 20'hABCDE);
    check_fail(1, "R8"); check_status(1, "R8"); check_status(0, "R8");
    access("R9", 64'h3000, 1, 0, 0, 8'd6, 20'h11111);
    check_fail(1, "R9"); check_status(1, "R9");

    // R11 reporting enable
    reg_wr(12'h000, 32'h0); m_act = 0;
    chk("R11", "irq masked", 64'(irq), 64'(0));
    reg_rd(12'h000, v); chk("R11", "ctrl", 64'(v), 64'(0));
    reg_wr(12'h000, 32'h1); m_act = 1;
    chk("R11", "irq unmasked", 64'(irq), 64'(1));
    do_clear();

    // R10 clear and violation in the same cycle
    access("R10", 64'h9000, 0, 1, 0, 8'd1, 20'd1);
    reg_we = 1; reg_addr = 12'h014; reg_wdata = 32'h1;
    req_valid = 1; req_addr = 64'h5000; req_write = 0; req_secure = 1;
    req_priv = 0; req_mid = 8'd7; req_aid = 20'h00042;
    @(posedge clk); @(negedge clk);
    reg_we = 0; req_valid = 0;
    m_clear(); m_log(0, 0, 64'h5000, 0, 0, 8'd7, 20'h00042);
    chk("R10", "allow", 64'(rsp_allow), 64'(0));
    check_status(0, "R10"); check_fail(0, "R10");
    do_clear();

    // R3 upper address half
    set_rgn(2, 64'h1_0000_0000, 64'h1_0000_0FFF, 32'hC000_0001, 32'h0);
    reg_rd(12'h144, v); chk("R3", "base hi", 64'(v), 64'(1));
    access("R3", 64'h1_0000_0800, 0, 1, 0, 8'd0, 20'd0);
    access("R6", 64'h0_0000_0800, 0, 1, 0, 8'd0, 20'd0);
    do_clear();

    // random phase
    for (int i = 0; i < 3; i++) set_rgn(i, 64'h0, 64'h0, 32'h0, 32'h0);
    for (int i = 3; i < 9; i++) begin
      logic [63:0] b;
      b = 64'($urandom_range(0, 40)) << 12;
      set_rgn(i, b, b + (64'($urandom_range(0, 8)) << 12) + 64'hFFF,
              {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 29'b0,
               $urandom_range(0, 7) != 0}, $urandom());
    end
    for (int k = 0; k < 400; k++) begin
      access("R6", (64'($urandom_range(0, 52)) << 12) | 64'($urandom_range(0, 4095)),
             $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
             $urandom_range(0, 1) == 1, 8'($urandom()), 20'($urandom()));
      if (k % 25 == 24) begin check_status(0, "R8"); check_status(1, "R8"); end
      if (k % 40 == 39) begin check_fail(k % 80 == 79 ? 1 : 0, "R8"); do_clear(); end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule